// File: doc/BRIEF.md
# SIMT Execution Mask Controller

This block sits on the scalar side of a SIMD wavefront and owns the per-lane execute mask, one bit per vector lane. Divergent structured control flow (if, else, loop, break, end) is handled by combining the current mask with the lane compare vector or with a saved copy of the mask. The saved copy travels through the register file as an ordinary operand, so the block holds no reconvergence stack. Besides the mask it reports a saved-mask result, an "all lanes off" flag that lets the sequencer skip a region, and a "loop again" flag for loop back-edges. It also handles pixel kill and the expansion of the mask to whole 2x2 quads.

A command is presented with `cmd_valid` for one cycle. Its results appear on the outputs after the next rising clock edge. Commands may arrive back to back, and each one sees the mask left by the command before it. The controller has two states. IDLE means no result is on show. RESP means a result from the previous cycle is on show. Moves between them: IDLE to RESP on an accepted command, RESP to RESP on a back-to-back command, RESP to IDLE when no command arrives, and any state to IDLE on reset.

Top module: `exmask_ctrl`

## Requirements
- R1: While reset is held and after it is released, with no command yet: `exec_mask` is all ones, `saved_out` is zero, and `exec_zero`, `loop_again` and `result_valid` are low.
- R2: IF (op code 1) sets exec = exec AND cmp and returns saved_out = exec AND NOT cmp, using the previous exec. So saved_out holds the lanes that skip the then-path.
- R3: ELSE (op code 2) returns saved_out = previous exec and sets exec = saved_in AND NOT previous exec. This equals (exec OR saved_in) XOR exec.
- R4: END (op code 3) sets exec = exec OR saved_in. It leaves saved_out unchanged.
- R5: LOOP (op code 4) sets exec = exec AND NOT saved_in. `loop_again` is high for the one result cycle exactly when that new exec is nonzero. After any other command, and after an idle cycle, `loop_again` is low.
- R6: BREAK (op code 5) returns exec OR saved_in. IF-BREAK (op code 6) returns cmp OR saved_in. ELSE-BREAK (op code 7) returns saved_in OR cmp. None of the three changes exec.
- R7: KILL (op code 8) treats each cmp bit as "lane value is negative" and sets exec = exec AND NOT cmp. A lane whose value is zero or positive (cmp bit 0) keeps its state. saved_out is unchanged.
- R8: `exec_zero` is high exactly when `exec_mask` is all zeros, on every cycle.
- R9: WQM (op code 9) sets all four bits of each aligned 4-lane group (lanes 4k..4k+3) when any bit of that group is set in exec. It leaves empty groups empty and saved_out unchanged.
- R10: With `cmd_valid` low, or with op code 0 or 10..15, exec and saved_out hold their values. With `cmd_valid` low, `result_valid` is low in the next cycle.
- R11: Results take effect one clock after `cmd_valid`, and `result_valid` is high for that one cycle. A command on the next cycle works on the updated exec.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 4 | Command code |
| cmp_mask | input | 64 | Per-lane compare or negative-value vector |
| saved_in | input | 64 | Saved-mask or break-mask operand |
| exec_mask | output | 64 | Current execute mask |
| saved_out | output | 64 | Saved-mask / break-mask result |
| exec_zero | output | 1 | No lane active |
| loop_again | output | 1 | Loop back-edge should be taken |
| result_valid | output | 1 | A command result is on show this cycle |

## Verification
Two functions often land in one result cycle. The first is a mask update that empties the mask. This happens with LOOP using a break mask that covers every live lane, KILL on all live lanes, or IF with a compare vector that misses every live lane. The second is the flag logic, which must then raise `exec_zero` while `loop_again` stays low. A back-to-back command in the following cycle must start from the emptied mask. The bench provokes these cases with directed sequences and with random operands drawn at several densities, including all-zero and all-one operands. A behavioural model in the bench predicts every output on every clock, and any difference is counted against the requirement of the command that caused it.

// File: rtl/exmask_pkg.sv
package exmask_pkg;
    typedef enum logic [3:0] {
        OP_NOP     = 4'd0,
        OP_IF      = 4'd1,
        OP_ELSE    = 4'd2,
        OP_END     = 4'd3,
        OP_LOOP    = 4'd4,
        OP_BRK     = 4'd5,
        OP_IFBRK   = 4'd6,
        OP_ELSEBRK = 4'd7,
        OP_KILL    = 4'd8,
        OP_QUAD    = 4'd9
    } exm_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } exm_state_e;
endpackage

// File: rtl/exmask_quad.sv
module exmask_quad #(
    parameter int LANES = 64,
    parameter int GRP   = 4
) (
    input  logic [LANES-1:0] mask_in,
    output logic [LANES-1:0] mask_out
);
    localparam int NGRP = LANES / GRP;

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        assign mask_out[g*GRP +: GRP] = {GRP{|mask_in[g*GRP +: GRP]}};
    end
endmodule

// File: rtl/exmask_alu.sv
module exmask_alu
    import exmask_pkg::*;
#(
    parameter int LANES = 64,
    parameter int GRP   = 4
) (
    input  logic [3:0]       op_raw,
    input  logic [LANES-1:0] exec_cur,
    input  logic [LANES-1:0] cmp,
    input  logic [LANES-1:0] saved,
    output logic [LANES-1:0] exec_nxt,
    output logic [LANES-1:0] dst,
    output logic             dst_we,
    output logic             loop_hit
);
    logic [LANES-1:0] quad_mask;
    logic [LANES-1:0] else_tmp;
    exm_op_e          op;

    assign op = exm_op_e'(op_raw);

    exmask_quad #(.LANES(LANES), .GRP(GRP)) u_quad (
        .mask_in  (exec_cur),
        .mask_out (quad_mask)
    );

    assign else_tmp = exec_cur | saved;

    always_comb begin
        exec_nxt = exec_cur;
        dst      = '0;
        dst_we   = 1'b0;
        unique case (op)
            OP_IF: begin
                exec_nxt = exec_cur & cmp;
                dst      = exec_cur ^ (exec_cur & cmp);
                dst_we   = 1'b1;
            end
            OP_ELSE: begin
                exec_nxt = else_tmp ^ exec_cur;
                dst      = exec_cur;
                dst_we   = 1'b1;
            end
            OP_END:  exec_nxt = exec_cur | saved;
            OP_LOOP: exec_nxt = exec_cur & ~saved;
            OP_BRK: begin
                dst    = exec_cur | saved;
                dst_we = 1'b1;
            end
            OP_IFBRK: begin
                dst    = cmp | saved;
                dst_we = 1'b1;
            end
            OP_ELSEBRK: begin
                dst    = saved | cmp;
                dst_we = 1'b1;
            end
            OP_KILL: exec_nxt = exec_cur & ~cmp;
            OP_QUAD: exec_nxt = quad_mask;
            default: exec_nxt = exec_cur;
        endcase
    end

    assign loop_hit = (op == OP_LOOP) && (|exec_nxt);
endmodule

// File: rtl/exmask_ctrl.sv
module exmask_ctrl
    import exmask_pkg::*;
#(
    parameter int LANES = 64,
    parameter int GRP   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [3:0]       cmd_op,
    input  logic [LANES-1:0] cmp_mask,
    input  logic [LANES-1:0] saved_in,
    output logic [LANES-1:0] exec_mask,
    output logic [LANES-1:0] saved_out,
    output logic             exec_zero,
    output logic             loop_again,
    output logic             result_valid
);
    exm_state_e       state_q, state_d;
    logic [LANES-1:0] alu_exec, alu_dst;
    logic             alu_dst_we, alu_loop;

    exmask_alu #(.LANES(LANES), .GRP(GRP)) u_alu (
        .op_raw   (cmd_op),
        .exec_cur (exec_mask),
        .cmp      (cmp_mask),
        .saved    (saved_in),
        .exec_nxt (alu_exec),
        .dst      (alu_dst),
        .dst_we   (alu_dst_we),
        .loop_hit (alu_loop)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (cmd_valid) state_d = ST_RESP;
            ST_RESP: state_d = cmd_valid ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exec_mask  <= '1;
            saved_out  <= '0;
            exec_zero  <= 1'b0;
            loop_again <= 1'b0;
        end else begin
            loop_again <= cmd_valid && alu_loop;
            if (cmd_valid) begin
                exec_mask <= alu_exec;
                exec_zero <= (alu_exec == '0);
                if (alu_dst_we) saved_out <= alu_dst;
            end
        end
    end

    assign result_valid = (state_q == ST_RESP);

    p_zero_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        exec_zero == (exec_mask == '0));

    p_loop_live_r5: assert property (@(posedge clk) disable iff (!rst_n)
        loop_again |-> !exec_zero);

    p_if_narrows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_IF) |=> ((exec_mask & ~$past(exec_mask)) == '0));

    p_end_widens_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_END) |=> ((exec_mask & $past(exec_mask)) == $past(exec_mask)));

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> ($stable(exec_mask) && $stable(saved_out) && !result_valid));

    p_resp_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> result_valid);
endmodule

// File: tb/tb_exmask_ctrl.sv
module tb_exmask_ctrl;
    localparam int L = 64;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_valid = 1'b0;
    logic [3:0]   cmd_op = 4'd0;
    logic [L-1:0] cmp_mask = '0;
    logic [L-1:0] saved_in = '0;
    logic [L-1:0] exec_mask, saved_out;
    logic         exec_zero, loop_again, result_valid;

    int n_cmp = 0;
    int n_bad = 0;

    logic [L-1:0] m_exec = '1, m_saved = '0;
    logic         m_loop = 1'b0, m_valid = 1'b0;
    string        m_req = "R1";

    always #2.5 clk = ~clk;

    exmask_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmp_mask(cmp_mask), .saved_in(saved_in), .exec_mask(exec_mask),
        .saved_out(saved_out), .exec_zero(exec_zero), .loop_again(loop_again),
        .result_valid(result_valid)
    );

    function automatic string req_of(input logic v, input logic [3:0] op);
        if (!v) return "R10";
        case (op)
            4'd1: return "R2";
            4'd2: return "R3";
            4'd3: return "R4";
            4'd4: return "R5";
            4'd5, 4'd6, 4'd7: return "R6";
            4'd8: return "R7";
            4'd9: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic compare();
        n_cmp++;
        if (exec_mask !== m_exec || saved_out !== m_saved || loop_again !== m_loop ||
            result_valid !== m_valid || exec_zero !== (m_exec == '0)) begin
            n_bad++;
            $display("FAIL %s (R8/R11 flags too): exec %h saved %h z%b l%b v%b expected exec %h saved %h z%b l%b v%b",
                     m_req, exec_mask, saved_out, exec_zero, loop_again, result_valid,
                     m_exec, m_saved, (m_exec == '0), m_loop, m_valid);
        end
    endtask

    // Apply one cycle of stimulus at the falling edge, update the model,
    // then compare at the next falling edge (one register stage, R11).
    task automatic step(input logic v, input logic [3:0] op,
                        input logic [L-1:0] c, input logic [L-1:0] s);
        logic [L-1:0] e0;
        cmd_valid = v; cmd_op = op; cmp_mask = c; saved_in = s;
        e0 = m_exec;
        m_valid = v;
        m_loop = 1'b0;
        m_req = req_of(v, op);
        if (v) begin
            case (op)
                4'd1: begin m_exec = e0 & c; m_saved = e0 & ~c; end
                4'd2: begin m_exec = s & ~e0; m_saved = e0; end
                4'd3: m_exec = e0 | s;
                4'd4: begin m_exec = e0 & ~s; m_loop = (m_exec != '0); end
                4'd5: m_saved = e0 | s;
                4'd6: m_saved = c | s;
                4'd7: m_saved = s | c;
                4'd8: m_exec = e0 & ~c;
                4'd9: for (int g = 0; g < L/4; g++)
                          m_exec[g*4 +: 4] = (e0[g*4 +: 4] != 4'b0) ? 4'hF : 4'h0;
                default: ;
            endcase
        end
        @(negedge clk);
        compare();
    endtask

    function automatic logic [L-1:0] rnd(input int dens);
        logic [L-1:0] r = {$urandom, $urandom};
        case (dens)
            0: return '0;
            1: return '1;
            2: return r & {$urandom, $urandom} & {$urandom, $urandom};
            default: return r;
        endcase
    endfunction

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : stim
        @(negedge clk);
        compare();                    // R1 during reset
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare();                    // R1 after reset
        // if / else / end
        step(1, 4'd1, 64'h00FF_00FF_F0F0_1234, '0);         // R2
        step(1, 4'd2, '0, m_saved);                         // R3
        step(1, 4'd3, '0, m_saved);                         // R4 restores
        // back-to-back and idle hold
        step(1, 4'd1, 64'h0, '0);                           // R2 empties mask, R8
        step(1, 4'd3, '0, 64'h8000_0000_0000_0001);         // R4 from empty, R11
        step(0, 4'd3, '1, '1);                              // R10 ignored
        step(1, 4'd15, '1, '1);                             // R10 unused op
        step(1, 4'd0, '1, '1);                              // R10 nop
        // quad expansion
        step(1, 4'd9, '0, '0);                              // R9
        step(1, 4'd3, '0, 64'h0000_0000_0000_0020);
        step(1, 4'd8, 64'h0000_0000_0000_00F0, '0);         // R7
        step(1, 4'd9, '0, '0);                              // R9 empty groups stay empty
        // loop with breaks
        step(1, 4'd3, '0, '1);
        step(1, 4'd5, '0, 64'h0F);                          // R6
        step(1, 4'd6, 64'hF0, 64'h0F00);                    // R6
        step(1, 4'd7, 64'h1, 64'h2);                        // R6
        step(1, 4'd4, '0, 64'hFFFF);                        // R5 loop again
        step(1, 4'd4, '0, '1);                              // R5 empties, no loop
        step(1, 4'd4, '0, '0);                              // R5 empty stays empty
        // kill
        step(1, 4'd3, '0, '1);
        step(1, 4'd8, '1, '0);                              // R7 all negative
        step(1, 4'd3, '0, '1);
        step(1, 4'd8, '0, '0);                              // R7 none negative
        // random mix
        for (int i = 0; i < 600; i++) begin
            logic [3:0] op = 4'($urandom_range(0, 15));
            step(($urandom_range(0, 5) != 0), op,
                 rnd($urandom_range(0, 3)), rnd($urandom_range(0, 3)));
            if ($urandom_range(0, 9) == 0) step(1, 4'd3, '0, '1);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule